// File: doc/BRIEF.md
# Two-Wire Clock-Control Register Slave

This block is the control-register slave of a clock distribution device. It listens on a two-wire serial bus (clock line and data line, SMBus style) in the system clock domain. Each line passes through a two-flop synchronizer, and the slave detects START and STOP conditions and clock edges on the synchronized values. When a write frame carries its 7-bit device address, the slave acknowledges the frame. The frame then supplies a command code, a byte count and register data. The data bytes update three control bytes in a fixed order.

The control bytes drive a ten-bit enable vector, with one bit for each differential output pair, and one test-mode bit that selects between normal operation and a PLL leakage test. A host can use these to gate individual output pairs. Reserved register bits have no effect and are not stored. The slave pulls the data line low to acknowledge a byte and never drives it high.

The bus is assumed to hold each clock-line level for at least three system clock cycles. It is also assumed not to change the data line in the same system cycle as a clock-line edge.

Top module: `tws_ctrl_slave`

## Requirements
- R1: After reset, all ten bits of `pairEnable` are 1 and `testNormal` is 1. This corresponds to the first data byte at 0xFF, the second at 0xC0 and the third at 0xFF.
- R2: After a START, the first byte is sent MSB first: seven address bits, then a direction bit. If the address equals `DEV_ADDR` and the direction bit is 0 (write), the byte is acknowledged.
- R3: If the address differs, or the direction bit is 1, the byte is not acknowledged. No further byte is then acknowledged or written until the next START.
- R4: After an acknowledged address, the next byte is a command code and the one after it is a byte count. Both are acknowledged, and neither changes any output.
- R5: In the first data byte, bit 7-k sets `pairEnable[k]` for k = 0..7. A 1 enables the pair and a 0 disables it.
- R6: In the second data byte, bit 7 sets `pairEnable[8]` and bit 6 sets `pairEnable[9]`. Bits 5..0 have no effect.
- R7: In the third data byte, bit 7 sets `testNormal`, where 0 selects the leakage test. Bits 6..0 have no effect.
- R8: Data bytes go to the first, second and third register in that order. Only the first min(byte count, 3) bytes are written, and a count of 0 writes nothing. Every data byte is acknowledged, including those not written.
- R9: A STOP that arrives before the count is used up leaves the unreached registers unchanged.
- R10: A START or STOP in the middle of a byte aborts the frame. The partial byte is discarded, and registers already written keep their new values.
- R11: `sdaPullLow` rises only after the falling clock edge that follows the eighth bit of an acknowledged byte. It falls at the falling edge of the ninth clock.
- R12: A START or STOP releases `sdaPullLow`. The slave acknowledges nothing between a STOP and the next START.
- R13: A repeated START, with no STOP before it, begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaPullLow | output | 1 | 1 = pull the data line low (acknowledge) |
| pairEnable | output | 10 | Enable for each output pair, bit k for pair k |
| testNormal | output | 1 | 1 = normal operation, 0 = PLL leakage test |

## Verification
The hardest situations to reach are frames broken off partway: a START or STOP arriving a few bits into a data byte, right after registers earlier in the same frame have been written. The same applies to a repeated START that lands before the count byte has finished. The stimulus builds these from bit-level tasks, so it can stop sending after any bit and issue a START or STOP while the clock line is low. A count of zero and a count larger than the register file push the write limit to both of its edges. A behavioural model, which delays the line levels by the synchronizer depth, predicts the acknowledge pulse cycle by cycle.

// File: rtl/tws_pkg.sv
package tws_pkg;

  localparam int BYTE_W     = 8;
  localparam int REG_COUNT  = 3;
  localparam int PAIR_COUNT = 10;
  localparam int SEL_W      = $clog2(REG_COUNT);
  localparam int TEST_REG   = 2;
  localparam int TEST_BIT   = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_DATA,
    ST_SKIP
  } busState_t;

  typedef struct packed {
    logic              startSeen;
    logic              stopSeen;
    logic              byteDone;
    logic [BYTE_W-1:0] rxByte;
  } busEvents_t;

  typedef struct packed {
    logic             ackArm;
    logic             regWrite;
    logic [SEL_W-1:0] regSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
  parameter int   STAGES     = 2,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineNow,
  output logic lineOld
);

  logic [STAGES-1:0] pipeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeQ   <= {STAGES{IDLE_LEVEL}};
      lineOld <= IDLE_LEVEL;
    end else begin
      pipeQ   <= {pipeQ[STAGES-2:0], lineIn};
      lineOld <= pipeQ[STAGES-1];
    end
  end

  assign lineNow = pipeQ[STAGES-1];

endmodule

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  ctrlStrobes_t          strobes,
  output busEvents_t            events,
  output logic                  sclSync,
  output logic                  sdaPullLow,
  output logic [PAIR_COUNT-1:0] pairEnable,
  output logic                  testNormal
);

  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_WAIT  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_HOLD  = CNT_W'(BYTE_W + 1);

  logic sclNow, sclOld, sdaNow, sdaOld;
  logic sclRise, sclFall, busBreak;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-2:0] shiftQ;
  logic              ackPending;

  tws_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_sclSync (
    .clk(clk), .rstN(rstN), .lineIn(sclIn), .lineNow(sclNow), .lineOld(sclOld)
  );

  tws_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_sdaSync (
    .clk(clk), .rstN(rstN), .lineIn(sdaIn), .lineNow(sdaNow), .lineOld(sdaOld)
  );

  assign sclSync = sclNow;
  assign sclRise = sclNow & ~sclOld;
  assign sclFall = ~sclNow & sclOld;

  always_comb begin
    events.startSeen = sclNow & sclOld & sdaOld & ~sdaNow;
    events.stopSeen  = sclNow & sclOld & ~sdaOld & sdaNow;
    events.byteDone  = sclRise && (bitCnt == LAST_DATA);
    events.rxByte    = {shiftQ, sdaNow};
  end

  assign busBreak = events.startSeen | events.stopSeen;

  // bit position within a byte, plus the two acknowledge sub-phases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      shiftQ     <= '0;
      ackPending <= 1'b0;
      sdaPullLow <= 1'b0;
    end else if (busBreak) begin
      bitCnt     <= '0;
      ackPending <= 1'b0;
      sdaPullLow <= 1'b0;
    end else if (sclRise && (bitCnt < ACK_WAIT)) begin
      shiftQ <= {shiftQ[BYTE_W-3:0], sdaNow};
      bitCnt <= bitCnt + 1'b1;
      if (events.byteDone) begin
        ackPending <= strobes.ackArm;
      end
    end else if (sclFall) begin
      if (bitCnt == ACK_WAIT) begin
        bitCnt     <= ACK_HOLD;
        sdaPullLow <= ackPending;
      end else if (bitCnt == ACK_HOLD) begin
        bitCnt     <= '0;
        ackPending <= 1'b0;
        sdaPullLow <= 1'b0;
      end
    end
  end

  // only the bits that have an effect are stored; pair p lives in
  // register p/8 at bit 7-(p%8)
  for (genvar p = 0; p < PAIR_COUNT; p++) begin : g_pair
    localparam int REG_OF = p / BYTE_W;
    localparam int BIT_OF = BYTE_W - 1 - (p % BYTE_W);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pairEnable[p] <= 1'b1;
      end else if (strobes.regWrite && (strobes.regSel == SEL_W'(REG_OF))) begin
        pairEnable[p] <= events.rxByte[BIT_OF];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testNormal <= 1'b1;
    end else if (strobes.regWrite && (strobes.regSel == SEL_W'(TEST_REG))) begin
      testNormal <= events.rxByte[TEST_BIT];
    end
  end

endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter logic [BYTE_W-2:0] DEV_ADDR = 7'h52
) (
  input  logic         clk,
  input  logic         rstN,
  input  busEvents_t   events,
  output ctrlStrobes_t strobes,
  output busState_t    busState
);

  localparam int IDX_W = $clog2(REG_COUNT + 1);

  logic [BYTE_W-1:0] countLeft;
  logic [IDX_W-1:0]  regIdx;
  logic              addrHit;
  logic              slotFree;

  assign addrHit  = (events.rxByte[BYTE_W-1:1] == DEV_ADDR) && !events.rxByte[0];
  assign slotFree = (regIdx < IDX_W'(REG_COUNT)) && (countLeft != '0);

  always_comb begin
    strobes = '0;
    if (events.byteDone) begin
      unique case (busState)
        ST_ADDR: strobes.ackArm = addrHit;
        ST_CMD,
        ST_CNT:  strobes.ackArm = 1'b1;
        ST_DATA: begin
          strobes.ackArm   = 1'b1;
          strobes.regWrite = slotFree;
          strobes.regSel   = SEL_W'(regIdx);
        end
        default: strobes = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busState  <= ST_IDLE;
      countLeft <= '0;
      regIdx    <= '0;
    end else if (events.startSeen) begin
      busState  <= ST_ADDR;
      countLeft <= '0;
      regIdx    <= '0;
    end else if (events.stopSeen) begin
      busState <= ST_IDLE;
    end else if (events.byteDone) begin
      unique case (busState)
        ST_ADDR: busState <= addrHit ? ST_CMD : ST_SKIP;
        ST_CMD:  busState <= ST_CNT;
        ST_CNT: begin
          busState  <= ST_DATA;
          countLeft <= events.rxByte;
          regIdx    <= '0;
        end
        ST_DATA: begin
          if (slotFree) begin
            regIdx    <= regIdx + 1'b1;
            countLeft <= countLeft - 1'b1;
          end
        end
        default: busState <= busState;
      endcase
    end
  end

endmodule

// File: rtl/tws_ctrl_slave.sv
module tws_ctrl_slave
  import tws_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h52,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaPullLow,
  output logic [PAIR_COUNT-1:0] pairEnable,
  output logic                  testNormal
);

  busEvents_t   busEv;
  ctrlStrobes_t ctrlStb;
  busState_t    busState;
  logic         sclSync;

  tws_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strobes(ctrlStb), .events(busEv), .sclSync(sclSync),
    .sdaPullLow(sdaPullLow), .pairEnable(pairEnable), .testNormal(testNormal)
  );

  tws_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .events(busEv), .strobes(ctrlStb), .busState(busState)
  );

endmodule

// File: rtl/tws_checker.sv
module tws_checker
  import tws_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  sdaPullLow,
  input logic                  sclSync,
  input logic                  startSeen,
  input logic                  stopSeen,
  input logic                  byteDone,
  input logic [PAIR_COUNT-1:0] pairEnable,
  input logic                  testNormal,
  input busState_t             busState
);

  AST_ACK_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclSync); // R11

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> !sdaPullLow); // R12

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaPullLow); // R12

  AST_WRITE_ON_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({pairEnable, testNormal}) |-> $past(byteDone)); // R8

  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_SKIP) |-> !sdaPullLow); // R3

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_IDLE) |-> !sdaPullLow); // R12

endmodule

bind tws_ctrl_slave tws_checker u_checker (
  .clk(clk), .rstN(rstN), .sdaPullLow(sdaPullLow), .sclSync(sclSync),
  .startSeen(busEv.startSeen), .stopSeen(busEv.stopSeen), .byteDone(busEv.byteDone),
  .pairEnable(pairEnable), .testNormal(testNormal), .busState(busState)
);

// File: tb/tb_tws_ctrl_slave.sv
module tb_tws_ctrl_slave;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam logic [6:0] ADDR = 7'h52;
  localparam logic [7:0] WR_ADDR = {ADDR, 1'b0};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclIn = 1'b1;
  logic       sdaIn = 1'b1;
  logic       sdaPullLow;
  logic [9:0] pairEnable;
  logic       testNormal;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  bit    compareOn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tws_ctrl_slave #(.DEV_ADDR(ADDR)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaPullLow(sdaPullLow), .pairEnable(pairEnable), .testNormal(testNormal)
  );

  // ---------------- behavioural reference model ----------------
  bit       qScl[$];
  bit       qSda[$];
  int       mBits, mShift, mState, mCount, mIdx;
  bit       mArm, mDrive;
  bit [7:0] mReg[3];

  function automatic bit [9:0] modelPairs();
    bit [9:0] v;
    for (int p = 0; p < 10; p++) v[p] = mReg[p / 8][7 - (p % 8)];
    return v;
  endfunction

  always @(posedge clk) begin
    bit cS, pS, cD, pD, ack;
    if (!rstN) begin
      qScl = '{1'b1, 1'b1, 1'b1};
      qSda = '{1'b1, 1'b1, 1'b1};
      mBits = 0; mShift = 0; mState = 0; mCount = 0; mIdx = 0;
      mArm = 0; mDrive = 0;
      mReg[0] = 8'hFF; mReg[1] = 8'hC0; mReg[2] = 8'hFF;
    end else begin
      pS = qScl[0]; cS = qScl[1]; pD = qSda[0]; cD = qSda[1];
      if (cS && pS && pD && !cD) begin
        mBits = 0; mArm = 0; mDrive = 0; mState = 1; mCount = 0; mIdx = 0;
      end else if (cS && pS && !pD && cD) begin
        mBits = 0; mArm = 0; mDrive = 0; mState = 0;
      end else if (cS && !pS && mBits < 8) begin
        mShift = ((mShift << 1) | int'(cD)) & 8'hFF;
        mBits++;
        if (mBits == 8) begin
          ack = 0;
          case (mState)
            1: begin
              if (mShift == int'(WR_ADDR)) begin ack = 1; mState = 2; end
              else mState = 5;
            end
            2: begin ack = 1; mState = 3; end
            3: begin ack = 1; mCount = mShift; mIdx = 0; mState = 4; end
            4: begin
              ack = 1;
              if (mIdx < 3 && mIdx < mCount) begin
                mReg[mIdx] = 8'(mShift);
                mIdx++;
              end
            end
            default: ack = 0;
          endcase
          mArm = ack;
        end
      end else if (!cS && pS) begin
        if (mBits == 8) begin mBits = 9; mDrive = mArm; end
        else if (mBits == 9) begin mBits = 0; mDrive = 0; mArm = 0; end
      end
      qScl.push_back(sclIn); void'(qScl.pop_front());
      qSda.push_back(sdaIn); void'(qSda.pop_front());
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (compareOn && rstN) begin
      checks++;
      if (sdaPullLow !== mDrive || pairEnable !== modelPairs() || testNormal !== mReg[2][7]) begin
        errors++;
        $display("FAIL %s per-cycle: sdaPullLow/pairEnable/testNormal act %0b/%h/%0b exp %0b/%h/%0b",
                 curReq, sdaPullLow, pairEnable, testNormal, mDrive, modelPairs(), mReg[2][7]);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaIn = 1'b1; idle(HALF);
    sclIn = 1'b1; idle(HALF);
    sdaIn = 1'b0; idle(HALF);
    sclIn = 1'b0; idle(HALF);
  endtask

  task automatic busStop();
    sdaIn = 1'b0; idle(HALF);
    sclIn = 1'b1; idle(HALF);
    sdaIn = 1'b1; idle(HALF);
  endtask

  task automatic sendBit(bit b);
    sdaIn = b;    idle(HALF);
    sclIn = 1'b1; idle(HALF);
    sclIn = 1'b0; idle(HALF);
  endtask

  task automatic sendByte(logic [7:0] b, bit expAck, string req);
    bit seen;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaIn = 1'b1; idle(HALF);
    sclIn = 1'b1; idle(HALF / 2);
    seen = sdaPullLow;
    idle(HALF / 2);
    sclIn = 1'b0; idle(HALF);
    check(seen == expAck, req, "acknowledge", int'(seen), int'(expAck));
  endtask

  task automatic checkOut(logic [9:0] expPairs, bit expTest, string req);
    check(pairEnable == expPairs, req, "pairEnable", int'(pairEnable), int'(expPairs));
    check(testNormal == expTest, req, "testNormal", int'(testNormal), int'(expTest));
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  // ---------------- stimulus ----------------
  initial begin
    idle(5);
    curReq = "R1";
    checkOut(10'h3FF, 1'b1, "R1");
    check(sdaPullLow == 1'b0, "R1", "sdaPullLow in reset", int'(sdaPullLow), 0);
    rstN = 1'b1;
    compareOn = 1'b1;
    idle(4);
    checkOut(10'h3FF, 1'b1, "R1");

    // R2 R4 R5 R6 R7 R11: full three-byte write
    curReq = "R5";
    busStart();
    sendByte(WR_ADDR, 1'b1, "R2");
    sendByte(8'h00, 1'b1, "R4");
    checkOut(10'h3FF, 1'b1, "R4");
    sendByte(8'h03, 1'b1, "R4");
    sendByte(8'h3A, 1'b1, "R5");
    sendByte(8'h80, 1'b1, "R6");
    sendByte(8'h7F, 1'b1, "R7");
    busStop();
    checkOut(10'h15C, 1'b0, "R5");

    // R3: wrong address, then read direction
    curReq = "R3";
    busStart();
    sendByte(8'hA6, 1'b0, "R3");
    sendByte(8'h00, 1'b0, "R3");
    sendByte(8'h03, 1'b0, "R3");
    sendByte(8'hFF, 1'b0, "R3");
    busStop();
    busStart();
    sendByte(8'hA5, 1'b0, "R3");
    sendByte(8'h00, 1'b0, "R3");
    busStop();
    checkOut(10'h15C, 1'b0, "R3");

    // R8: count limits the writes, extra bytes acknowledged
    curReq = "R8";
    busStart();
    sendByte(WR_ADDR, 1'b1, "R2");
    sendByte(8'h11, 1'b1, "R4");
    sendByte(8'h01, 1'b1, "R4");
    sendByte(8'hFF, 1'b1, "R8");
    sendByte(8'h00, 1'b1, "R8");
    sendByte(8'h00, 1'b1, "R8");
    busStop();
    checkOut(10'h1FF, 1'b0, "R8");

    // R9: STOP before count is used up
    curReq = "R9";
    busStart();
    sendByte(WR_ADDR, 1'b1, "R2");
    sendByte(8'h00, 1'b1, "R4");
    sendByte(8'h03, 1'b1, "R4");
    sendByte(8'h0F, 1'b1, "R9");
    busStop();
    checkOut(10'h1F0, 1'b0, "R9");

    // R10: STOP four bits into the third data byte
    curReq = "R10";
    busStart();
    sendByte(WR_ADDR, 1'b1, "R2");
    sendByte(8'h00, 1'b1, "R4");
    sendByte(8'h03, 1'b1, "R4");
    sendByte(8'hC1, 1'b1, "R10");
    sendByte(8'h40, 1'b1, "R6");
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    busStop();
    checkOut(10'h283, 1'b0, "R10");

    // R13: repeated START inside the count byte, then a full frame
    curReq = "R13";
    busStart();
    sendByte(WR_ADDR, 1'b1, "R2");
    sendByte(8'h00, 1'b1, "R4");
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b0);
    busStart();
    sendByte(WR_ADDR, 1'b1, "R13");
    sendByte(8'h00, 1'b1, "R13");
    sendByte(8'h03, 1'b1, "R13");
    sendByte(8'hFF, 1'b1, "R13");
    sendByte(8'hC0, 1'b1, "R13");
    sendByte(8'h80, 1'b1, "R7");
    busStop();
    checkOut(10'h3FF, 1'b1, "R13");

    // R8: count of zero writes nothing
    curReq = "R8";
    busStart();
    sendByte(WR_ADDR, 1'b1, "R2");
    sendByte(8'h00, 1'b1, "R4");
    sendByte(8'h00, 1'b1, "R4");
    sendByte(8'h00, 1'b1, "R8");
    busStop();
    checkOut(10'h3FF, 1'b1, "R8");

    // R8: count above register count
    busStart();
    sendByte(WR_ADDR, 1'b1, "R2");
    sendByte(8'h00, 1'b1, "R4");
    sendByte(8'h05, 1'b1, "R4");
    sendByte(8'h00, 1'b1, "R8");
    sendByte(8'h3F, 1'b1, "R6");
    sendByte(8'h00, 1'b1, "R8");
    sendByte(8'hFF, 1'b1, "R8");
    sendByte(8'hFF, 1'b1, "R8");
    busStop();
    checkOut(10'h000, 1'b0, "R8");

    // R10 R12: START mid-byte, then a foreign address is ignored
    curReq = "R12";
    busStart();
    sendByte(WR_ADDR, 1'b1, "R2");
    sendByte(8'h00, 1'b1, "R4");
    sendByte(8'h03, 1'b1, "R4");
    sendByte(8'hFF, 1'b1, "R10");
    for (int i = 0; i < 5; i++) sendBit(1'b0);
    busStart();
    sendByte(8'hB0, 1'b0, "R3");
    sendByte(8'h00, 1'b0, "R12");
    busStop();
    sendByte(8'hA4, 1'b0, "R12");
    checkOut(10'h0FF, 1'b0, "R10");

    idle(10);
    compareOn = 1'b0;
    finishRun();
  end

endmodule